// File: doc/BRIEF.md
# AC Bias Transition Interrupt Counter

This block counts inversions of a display panel's AC bias output and raises a sticky status flag once a programmed number of inversions has occurred. The flag serves as an interrupt request, and software clears it. The bias generator supplies a one-cycle toggle pulse for each inversion. A 4-bit programmed value sets how many inversions make up one period, from 1 to 15. A programmed value of zero turns the feature off.

When the controller enable rises, the counter loads the programmed value. It then counts down once for each toggle pulse. When it reaches zero it sets the status flag and reloads at once. It then stays frozen until software clears the flag. The interrupt output is the status flag gated by a mask input and taken through one register.

Top module: `bias_irq_counter`

## Requirements
- R1: After a synchronous active-high reset, `status` and `irq` are 0.
- R2: When `enable` rises, the counter loads `trans_count` on that clock edge. Toggle pulses from the next cycle onward are counted.
- R3: With `trans_count` = N (1 to 15), the N-th counted toggle pulse sets `status`, which is visible after the clock edge that samples that pulse. Pulses 1 to N-1 leave `status` at 0.
- R4: `status` is sticky. While it is 1, toggle pulses do not change the counter. After the flag is set, the counter holds a fresh copy of `trans_count`, so after a clear it takes exactly N more pulses to set the flag again.
- R5: With `trans_count` = 0, toggle pulses never set `status`.
- R6: `clr_status` clears `status` on the next edge and takes priority over a toggle pulse in the same cycle. That toggle is not counted.
- R7: Deasserting `enable` clears the counter and blocks counting, but leaves `status` unchanged. On re-enable the count starts again from the full programmed value.
- R8: `irq` equals the registered AND of `status` and `irq_mask`. It follows them one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable |
| trans_count | input | CNT_W | Inversions per interrupt; 0 disables |
| toggle | input | 1 | One-cycle pulse for each bias inversion |
| clr_status | input | 1 | Software clear strobe for the status flag |
| irq_mask | input | 1 | Interrupt enable mask |
| status | output | 1 | Sticky expiry flag |
| irq | output | 1 | Registered masked interrupt request |

## Verification
The counter value is hidden, so a wrong internal count shows up only as `status` rising on the wrong pulse. An off-by-one load or decrement moves the flag by one pulse within the first period. A missing reload, or counting while frozen, shortens the second period after a clear. The bench sweeps every programmed value and checks the flag after every single pulse, so any such error is caught within two periods. Enable and clear corner cases are checked the same way, by counting the pulses needed before the next expiry.

// File: rtl/bias_irq_pkg.sv
package bias_irq_pkg;
  localparam int unsigned DEFAULT_CNT_W = 4;

  typedef enum logic {
    ST_OFF   = 1'b0,
    ST_COUNT = 1'b1
  } cnt_state_t;
endpackage

// File: rtl/bic_down_counter.sv
module bic_down_counter
  import bias_irq_pkg::*;
#(
  parameter int unsigned CNT_W = DEFAULT_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] prog,
  input  logic             toggle,
  input  logic             clr,
  input  logic             frozen,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cnt_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             prog_on;
  logic             step;

  assign prog_on = (prog != '0);
  assign step    = (state_q == ST_COUNT) && enable && !frozen && !clr &&
                   toggle && prog_on && (cnt_q != '0);
  assign expire  = step && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else if (!enable) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else if (state_q == ST_OFF) begin
      state_q <= ST_COUNT;
      cnt_q   <= prog;
    end else if (expire) begin
      cnt_q <= prog;
    end else if (step) begin
      cnt_q <= cnt_q - ONE;
    end else if ((cnt_q == '0) && prog_on) begin
      cnt_q <= prog;
    end
  end

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COUNT && enable && frozen && !(cnt_q == '0 && prog_on)) |=> $stable(cnt_q)); // R4
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (cnt_q == '0)); // R7
  AST_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
    (prog == '0) |-> !expire); // R5
  AST_LOAD_ON_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (enable && state_q == ST_OFF) |=> (cnt_q == $past(prog))); // R2
endmodule

// File: rtl/bic_status_flag.sv
module bic_status_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic status
);
  always_ff @(posedge clk) begin
    if (rst)      status <= 1'b0;
    else if (clr) status <= 1'b0;
    else if (set) status <= 1'b1;
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> !status); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status && !clr) |=> status); // R4
  AST_SET_SEEN: assert property (@(posedge clk) disable iff (rst)
    (set && !clr) |=> status); // R3
endmodule

// File: rtl/bic_irq_out.sv
module bic_irq_out (
  input  logic clk,
  input  logic rst,
  input  logic status,
  input  logic mask,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= status & mask;
  end

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !mask |=> !irq); // R8
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (status && mask) |=> irq); // R8
endmodule

// File: rtl/bias_irq_counter.sv
module bias_irq_counter
  import bias_irq_pkg::*;
#(
  parameter int unsigned CNT_W = DEFAULT_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] trans_count,
  input  logic             toggle,
  input  logic             clr_status,
  input  logic             irq_mask,
  output logic             status,
  output logic             irq
);
  logic expire;

  bic_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .enable(enable), .prog(trans_count),
    .toggle(toggle), .clr(clr_status), .frozen(status), .expire(expire)
  );

  bic_status_flag u_flag (
    .clk(clk), .rst(rst), .set(expire), .clr(clr_status), .status(status)
  );

  bic_irq_out u_irq (
    .clk(clk), .rst(rst), .status(status), .mask(irq_mask), .irq(irq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!status && !irq)); // R1
endmodule

// File: tb/test_bias_irq_counter.sv
module test_bias_irq_counter;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [W-1:0] trans_count = '0;
  logic toggle = 1'b0;
  logic clr_status = 1'b0;
  logic irq_mask = 1'b0;
  logic status;
  logic irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bias_irq_counter #(.CNT_W(W)) i_bias_irq_counter (
    .clk(clk), .rst(rst), .enable(enable), .trans_count(trans_count),
    .toggle(toggle), .clr_status(clr_status), .irq_mask(irq_mask),
    .status(status), .irq(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) toggle = 1'b1;
    @(negedge clk) toggle = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk) clr_status = 1'b1;
    @(negedge clk) clr_status = 1'b0;
  endtask

  task automatic start(input int n);
    @(negedge clk) begin enable = 1'b0; trans_count = W'(n); end
    @(negedge clk) enable = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 status", status, 1'b0);
    check("R1 irq", irq, 1'b0);
    rst = 1'b0;

    // R2 R3 R4: sweep of all nonzero programmed values
    for (int n = 1; n < (1 << W); n++) begin
      start(n);
      for (int k = 1; k <= n; k++) begin
        pulse();
        check("R3 count", status, (k == n));
      end
      for (int k = 0; k < 3; k++) begin
        pulse();
        check("R4 frozen", status, 1'b1);
      end
      clear();
      check("R6 cleared", status, 1'b0);
      for (int k = 1; k <= n; k++) begin
        pulse();
        check("R4 reload", status, (k == n));
      end
      clear();
    end

    // R5: zero disables
    start(0);
    for (int k = 0; k < 40; k++) begin
      pulse();
      check("R5 off", status, 1'b0);
    end

    // R7: disable mid-count restarts from the full value
    start(5);
    repeat (3) pulse();
    start(5);
    for (int k = 1; k <= 5; k++) begin
      pulse();
      check("R7 restart", status, (k == 5));
    end
    // R7: status kept over disable
    @(negedge clk) enable = 1'b0;
    repeat (3) pulse();
    check("R7 sticky", status, 1'b1);
    clear();

    // R6: clear beats a simultaneous toggle
    start(2);
    pulse();
    check("R6 pre", status, 1'b0);
    @(negedge clk) begin clr_status = 1'b1; toggle = 1'b1; end
    @(negedge clk) begin clr_status = 1'b0; toggle = 1'b0; end
    check("R6 toggle ignored", status, 1'b0);
    pulse();
    check("R6 count resumes", status, 1'b1);

    // R8: mask gating with one cycle of delay
    check("R8 masked", irq, 1'b0);
    @(negedge clk) irq_mask = 1'b1;
    @(negedge clk);
    check("R8 unmasked", irq, 1'b1);
    @(negedge clk) irq_mask = 1'b0;
    @(negedge clk);
    check("R8 remasked", irq, 1'b0);
    @(negedge clk) irq_mask = 1'b1;
    @(negedge clk);
    clear();
    @(negedge clk);
    check("R8 clear drops irq", irq, 1'b0);

    // R1: reset mid-operation
    start(1);
    pulse();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R1 rst status", status, 1'b0);
    check("R1 rst irq", irq, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule